// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple clocked request port to an asynchronous static RAM that has 32K locations of one byte each. The requester presents a strobe, a read/write flag, a 15-bit address and a byte of write data while the controller reports that it is ready. The controller then runs the active-low chip-select, output-enable and write-enable strobes, along with the address bus and a tri-stated data bus, through a fixed sequence of phases. It ends every operation with a one-cycle completion pulse. For reads, the captured byte is presented together with that pulse.

Every analog timing limit of the memory is a nanosecond parameter. The clock period is one more parameter. Each limit is turned into a whole number of clock cycles by rounding up. The data bus is split into an outgoing byte, an incoming byte and a driver enable, so the pad-level tri-state buffer can sit outside the block. The controller turns its driver on only after the memory's outputs are guaranteed to float. It turns the driver off again before output-enable can fall.

Top module: `sram_ctrl`

## Requirements
- R1: During and after synchronous reset, chip-select, output-enable and write-enable are all high, the data driver enable is low, the completion pulse is low and the ready output is high.
- R2: A read holds chip-select low, output-enable low and write-enable high for exactly N_RD cycles. N_RD is the largest of the read cycle time, address access time and output-enable access time, divided by the clock period and rounded up (7 at the defaults). The byte on the incoming data bus is captured at the clock edge that ends this window.
- R3: A write holds chip-select and write-enable low together with output-enable high. It does so for at least the largest of the write cycle time, write pulse width and address-to-end-of-write time, rounded up to cycles (7 at the defaults).
- R4: The data driver is never enabled in a cycle where chip-select and output-enable are both low. It is enabled only after write-enable has been low for ceil(max(write-to-float, disable-to-float)/period) cycles (3 at the defaults).
- R5: Write data is driven for at least ceil(data setup/period) cycles (3 at the defaults) before the strobes rise. The driver stays on for one cycle after the strobes rise, and the driven byte is what the memory stores.
- R6: Each accepted request produces exactly one completion pulse of one cycle, raised only after the strobes are released. It appears N_RD cycles after acceptance for a read and write-window-plus-one cycles (8 at the defaults) for a write. On a read, the read data output holds the captured byte in that cycle.
- R7: A request is accepted only at a clock edge where the ready output is high. A request strobe raised while the ready output is low has no effect on the memory.
- R8: Address and write data are registered at acceptance and held stable on the memory side for the whole operation, whatever the request inputs do meanwhile.
- R9: The full 15-bit address range is usable, including address 0 and address 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with done after a read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Byte to drive onto the memory data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Byte read from the memory data bus |

## Verification
The bench pairs the controller with a memory model. The model returns a garbage byte until output-enable has been low for the full access count, so a controller that samples one cycle early reads the wrong value. Back-to-back write-then-read and read-then-write traffic checks bus turnaround. A controller that drives too early or leaves its driver on into a read shows up as contention or as a drive inside the float window. Request inputs are scrambled during every operation, and spurious strobes are raised while the controller is busy. A design that fails to register the inputs, or that accepts requests while busy, then stores the wrong byte or makes an extra write. The addresses at both ends of the range and the exact completion latency of each operation type are also checked.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WFLOAT,
        PH_WDRIVE,
        PH_WHOLD
    } phase_e;

    // Memory-side strobe bundle, all strobes active low
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t phase_strobes(phase_e ph);
        strobe_t s;
        s = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (ph)
            PH_READ:   begin s.cs_n = 1'b0; s.oe_n = 1'b0; end
            PH_WFLOAT: begin s.cs_n = 1'b0; s.we_n = 1'b0; end
            PH_WDRIVE: begin s.cs_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
            PH_WHOLD:  begin s.drive = 1'b1; end
            default:   ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_RD  = 7,
    parameter int unsigned N_FLT = 3,
    parameter int unsigned N_DRV = 4,
    parameter int unsigned CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          timer_expired,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output phase_e        phase,
    output strobe_t       strobes,
    output logic          accept,
    output logic          finish_rd,
    output logic          finish_wr
);
    phase_e  phase_q, phase_d;
    strobe_t strb_q;

    always_comb begin
        phase_d    = phase_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        finish_rd  = 1'b0;
        finish_wr  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    if (req_write) begin
                        phase_d   = PH_WFLOAT;
                        timer_val = CW'(N_FLT - 1);
                    end else begin
                        phase_d   = PH_READ;
                        timer_val = CW'(N_RD - 1);
                    end
                end
            end
            PH_READ: begin
                if (timer_expired) begin
                    phase_d   = PH_IDLE;
                    finish_rd = 1'b1;
                end
            end
            PH_WFLOAT: begin
                if (timer_expired) begin
                    phase_d    = PH_WDRIVE;
                    timer_load = 1'b1;
                    timer_val  = CW'(N_DRV - 1);
                end
            end
            PH_WDRIVE: begin
                if (timer_expired) begin
                    phase_d    = PH_WHOLD;
                    timer_load = 1'b1;
                    timer_val  = '0;
                end
            end
            PH_WHOLD: begin
                phase_d   = PH_IDLE;
                finish_wr = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Strobes are registered from the next phase so they change only at edges
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            strb_q  <= phase_strobes(PH_IDLE);
        end else begin
            phase_q <= phase_d;
            strb_q  <= phase_strobes(phase_d);
        end
    end

    assign phase   = phase_q;
    assign strobes = strb_q;

    // R2: a read window is not cut short while the timer is still running
    assert_read_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && !timer_expired) |=> (phase_q == PH_READ));

    // R5: the data hold phase lasts a single cycle
    assert_hold_single_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WHOLD) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          busy,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          finish_rd,
    input  logic          finish_wr,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          done_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (finish_rd) begin
                rdata_q <= mem_dq_in;
            end
            done_q <= finish_rd | finish_wr;
        end
    end

    // R8: memory-side address and data stay put while an operation runs
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));

    // R6: completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW            = 15,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_HZ_NS       = 25,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_WP_NS       = 50,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_DW_NS       = 25,
    parameter int unsigned T_WHZ_NS      = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned N_RD   = umax(1, ns_to_cycles(umax(T_RC_NS, umax(T_AA_NS, T_OE_NS)), CLK_PERIOD_NS));
    localparam int unsigned N_FLT  = umax(1, ns_to_cycles(umax(T_WHZ_NS, T_HZ_NS), CLK_PERIOD_NS));
    localparam int unsigned N_DS   = umax(1, ns_to_cycles(T_DW_NS, CLK_PERIOD_NS));
    localparam int unsigned N_WMIN = ns_to_cycles(umax(T_WC_NS, umax(T_WP_NS, T_AW_NS)), CLK_PERIOD_NS);
    localparam int unsigned N_REST = (N_WMIN > N_FLT) ? (N_WMIN - N_FLT) : 0;
    localparam int unsigned N_DRV  = umax(N_DS, N_REST);
    localparam int unsigned N_MAX  = umax(N_RD, umax(N_FLT, N_DRV));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    logic          timer_load, timer_expired;
    logic [CW-1:0] timer_val;
    phase_e        phase;
    strobe_t       strobes;
    logic          accept, finish_rd, finish_wr;

    sram_phase_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    sram_seq_fsm #(.N_RD(N_RD), .N_FLT(N_FLT), .N_DRV(N_DRV), .CW(CW)) fsm_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .phase         (phase),
        .strobes       (strobes),
        .accept        (accept),
        .finish_rd     (finish_rd),
        .finish_wr     (finish_wr)
    );

    sram_datapath #(.AW(AW), .DW(DW)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .busy      (phase != PH_IDLE),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .finish_rd (finish_rd),
        .finish_wr (finish_wr),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rdata),
        .done_q    (done)
    );

    assign req_ready = (phase == PH_IDLE);
    assign mem_cs_n  = strobes.cs_n;
    assign mem_oe_n  = strobes.oe_n;
    assign mem_we_n  = strobes.we_n;
    assign mem_dq_oe = strobes.drive;

    // R4: own driver never fights a memory that is driving the bus
    assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n || mem_cs_n));

    // R4: driver turns on only after write-enable has already been low
    assert_drive_after_float_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    // R6: completion is reported only once the strobes are released
    assert_done_released_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_cs_n && mem_we_n && mem_oe_n));
endmodule

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;
    localparam int CLK_NS = 10;

    function automatic int cyc(int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int EXP_RD  = 7;   // ceil(70/10)
    localparam int EXP_FLT = 3;   // ceil(25/10)
    localparam int EXP_DS  = 3;   // ceil(25/10)
    localparam int EXP_WR  = 7;   // ceil(70/10)
    localparam logic [14:0] POKE_A = 15'h1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int total = 0, bad = 0;
    int contention = 0, early_drive = 0, double_done = 0;
    int commits = 0, wr_issued = 0;
    bit finished = 0;

    logic [7:0] model_mem [int];
    logic [7:0] ref_mem   [int];

    always #(CLK_NS/2) clk = ~clk;

    sram_ctrl dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rd(input logic [14:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    // Memory model, evaluated mid-cycle
    int  rd_cnt = 0, wcnt = 0, dcnt = 0;
    bit  wr_prev = 0, rd_prev = 0, done_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            bit rd_now, wr_now;
            rd_now = !mem_cs_n && !mem_oe_n && mem_we_n;
            wr_now = !mem_cs_n && !mem_we_n;
            if (mem_dq_oe && !mem_cs_n && !mem_oe_n) contention++;
            if (done && done_prev) double_done++;
            done_prev = done;
            if (wr_now) begin
                if (mem_dq_oe) begin
                    if (dcnt == 0 && wcnt < EXP_FLT) early_drive++;
                    dcnt++;
                end
                wcnt++;
            end else if (wr_prev) begin
                check(wcnt >= EXP_WR, "R3 write strobe length", wcnt, EXP_WR);
                check(dcnt >= EXP_DS, "R5 data setup cycles", dcnt, EXP_DS);
                check(mem_dq_oe && !mem_oe_n == 1'b0, "R5 data hold after strobes", mem_dq_oe, 1);
                model_mem[int'(mem_addr)] = mem_dq_out;
                commits++;
                wcnt = 0;
                dcnt = 0;
            end
            wr_prev = wr_now;
            if (rd_now) rd_cnt++;
            else begin
                if (rd_prev) check(rd_cnt == EXP_RD, "R2 read window length", rd_cnt, EXP_RD);
                rd_cnt = 0;
            end
            rd_prev = rd_now;
            if (rd_now && rd_cnt >= EXP_RD)
                mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hEE;
        end
    end

    // Issue one operation; called right after a negedge, returns at the done negedge
    task automatic do_op(input bit w, input logic [14:0] a, input logic [7:0] d,
                         input bit poke, output logic [7:0] rd, output int lat);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        if (w) begin ref_mem[int'(a)] = d; wr_issued++; end
        lat = 0;
        forever begin
            @(negedge clk);
            if (lat == 0) begin
                req_valid = 1'b0;
                req_write = 1'($urandom);
                req_addr  = 15'($urandom);
                req_wdata = 8'($urandom);
            end
            if (done) break;
            lat++;
            if (poke && lat == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = POKE_A; req_wdata = 8'hA5;
            end
            if (poke && lat == 4) req_valid = 1'b0;
            if (lat > 100) break;
        end
        rd = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lat;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        // R1: reset state
        check({mem_cs_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_oe && !done, "R1 driver and done in reset", {mem_dq_oe, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 idle bus after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

        // R9: range ends, R6: latencies
        do_op(1'b1, 15'h0000, 8'h3C, 1'b0, rd, lat);
        check(lat == EXP_WR + 1, "R6 write latency", lat, EXP_WR + 1);
        do_op(1'b1, 15'h7FFF, 8'hC3, 1'b0, rd, lat);
        do_op(1'b0, 15'h0000, 8'h00, 1'b0, rd, lat);
        check(lat == EXP_RD, "R6 read latency", lat, EXP_RD);
        check(rd == 8'h3C, "R9 read address 0", rd, 8'h3C);
        do_op(1'b0, 15'h7FFF, 8'h00, 1'b0, rd, lat);
        check(rd == 8'hC3, "R9 read address 7FFF", rd, 8'hC3);

        // R7: request raised while busy is ignored
        do_op(1'b1, 15'h0042, 8'h5A, 1'b1, rd, lat);
        do_op(1'b0, POKE_A, 8'h00, 1'b0, rd, lat);
        check(rd == ref_rd(POKE_A), "R7 busy request ignored", rd, ref_rd(POKE_A));
        do_op(1'b0, 15'h0042, 8'h00, 1'b1, rd, lat);
        check(rd == 8'h5A, "R8 data held during op", rd, 8'h5A);

        // Random traffic, back to back with occasional gaps
        for (int i = 0; i < 400; i++) begin
            bit w;
            logic [14:0] a;
            logic [7:0] d;
            w = 1'($urandom);
            a = ($urandom_range(0, 3) == 0) ? 15'($urandom) : 15'($urandom_range(0, 15));
            d = 8'($urandom);
            do_op(w, a, d, 1'b0, rd, lat);
            if (w) check(lat == cyc(70) + 1, "R6 write latency random", lat, cyc(70) + 1);
            else begin
                check(lat == cyc(70), "R6 read latency random", lat, cyc(70));
                check(rd == ref_rd(a), "R2 read data random", rd, ref_rd(a));
            end
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 2)) @(negedge clk);
        end

        repeat (3) @(negedge clk);
        check(contention == 0, "R4 bus contention cycles", contention, 0);
        check(early_drive == 0, "R4 drive inside float window", early_drive, 0);
        check(double_done == 0, "R6 done longer than one cycle", double_done, 0);
        check(commits == wr_issued, "R7 memory write count", commits, wr_issued);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule